// File: doc/BRIEF.md
# Bunch Position Feedback Datapath

This block converts one pair of signed beam-position pickup samples into one kicker drive word per bunch. The two channel samples arrive together with a valid strobe. The block takes their difference as the raw position and takes their sum as a measure of bunch charge. It looks up a reciprocal of the sum's magnitude in an internal table and multiplies the difference by that reciprocal, so the position no longer depends on charge. It then rescales the product and multiplies it by a power of two chosen from eight settings.

The scaled position is the correction for the current bunch. A delay loop can add the correction that was applied to the previous bunch, so corrections build up along a train. A train-start pulse empties that stored value. Separate switches enable feedback, enable the delay loop and negate the output. Nothing saturates: every result wraps into the 14-bit two's complement output field. The output word and its strobe appear four clock cycles after the input strobe.

Top module: `beam_fb_datapath`

## Requirements
- R1: Each `in_valid` pulse accepted at a rising edge produces one `out_valid` pulse exactly four rising edges later. `out_valid` is low at every other time.
- R2: The scaled position is `((a-b) * T[i]) >>> 12`, an arithmetic shift. The index `i` is bits 14..7 of the 15-bit magnitude `|a+b|`. Table entry `T[i]` equals floor(65535/(i+1)), an unsigned Q0.16 value.
- R3: Gain select `g` (0..7) shifts the scaled position left by `g` bits, giving gains of x1 to x128.
- R4: No result saturates. The correction and the output word are the low 14 bits, in two's complement, of the exact result.
- R5: With `dly_en` high, the correction is the shifted position plus the stored correction of the previous bunch. Every bunch output while `fb_en` is high stores its own pre-inversion correction.
- R6: A `train_start` pulse clears the stored correction to zero. It overrides any store made in the same cycle.
- R7: With `invert` high, the output word is the two's complement negation of the correction. The stored value is the correction before inversion.
- R8: With `fb_en` low, the output word of that bunch is zero and the stored correction keeps its value.
- R9: After reset, `out_valid` is low, `out_word` is zero and the stored correction is zero.
- R10: `out_word` keeps its value between `out_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks a sample pair for one bunch |
| ch_a | input | 14 | Pickup channel A sample, signed |
| ch_b | input | 14 | Pickup channel B sample, signed |
| gain_sel | input | 3 | Left-shift amount of the gain, 0..7 |
| fb_en | input | 1 | Feedback enable; output is zero when low |
| dly_en | input | 1 | Adds the previous correction when high |
| invert | input | 1 | Negates the output word when high |
| train_start | input | 1 | Clears the stored correction |
| out_valid | output | 1 | Marks a new drive word |
| out_word | output | 14 | Kicker drive word, signed |

## Verification
The main function is driven with sample pairs of both sign orders and with sums that land on low, middle and top table indices. These cases separate a correct difference, index and reciprocal from swapped channels or a wrong index slice. Every gain setting is applied to one fixed pair, and a wide pair at x128 shows wrapping rather than clipping. A three-bunch train with the delay loop on, followed by a train-start pulse, tells accumulation apart from plain repetition. Interleaved inverted and feedback-off bunches show that the stored value is the pre-inversion correction and is left alone while feedback is off.

// File: rtl/fbdp_pkg.sv
package fbdp_pkg;
    localparam int SMP_W  = 14;
    localparam int OUT_W  = 14;
    localparam int RCP_W  = 16;
    localparam int IDX_W  = 8;
    localparam int GAIN_W = 3;
    localparam int SUM_W  = SMP_W + 1;
    localparam int PROD_W = SUM_W + RCP_W + 1;

    typedef struct packed {
        logic                    vld;
        logic signed [SUM_W-1:0] diff;
        logic        [SUM_W-1:0] mag;
    } st1_t;

    typedef struct packed {
        logic                    vld;
        logic signed [SUM_W-1:0] diff;
        logic        [RCP_W-1:0] rcp;
    } st2_t;

    typedef struct packed {
        logic                    vld;
        logic signed [OUT_W-1:0] pos;
    } st3_t;

    typedef struct packed {
        logic                    vld;
        logic signed [OUT_W-1:0] word;
        logic signed [OUT_W-1:0] acc;
    } st4_t;
endpackage

// File: rtl/fbdp_sumdiff.sv
module fbdp_sumdiff
    import fbdp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [SMP_W-1:0] ch_a,
    input  logic signed [SMP_W-1:0] ch_b,
    output st1_t                    s1_q
);
    st1_t                    s1_d;
    logic signed [SUM_W-1:0] a_x;
    logic signed [SUM_W-1:0] b_x;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        a_x       = {ch_a[SMP_W-1], ch_a};
        b_x       = {ch_b[SMP_W-1], ch_b};
        sum       = a_x + b_x;
        s1_d.vld  = in_valid;
        s1_d.diff = a_x - b_x;
        // magnitude of the charge sum; -2^(SUM_W-1) maps to 2^(SUM_W-1) unsigned
        s1_d.mag  = sum[SUM_W-1] ? -sum : sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s1_q <= '0;
        else        s1_q <= s1_d;
    end
endmodule

// File: rtl/fbdp_recip_rom.sv
module fbdp_recip_rom #(
    parameter int IDX_W = 8,
    parameter int RCP_W = 16
) (
    input  logic [IDX_W-1:0] idx,
    output logic [RCP_W-1:0] rcp
);
    localparam int DEPTH = 2 ** IDX_W;
    localparam int FULL  = (2 ** RCP_W) - 1;

    logic [RCP_W-1:0] tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign tbl[i] = RCP_W'(FULL / (i + 1));
    end

    assign rcp = tbl[idx];
endmodule

// File: rtl/fbdp_scale.sv
module fbdp_scale
    import fbdp_pkg::*;
#(
    parameter int NORM_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  st1_t              s1_q,
    input  logic [GAIN_W-1:0] gain_sel,
    output st3_t              s3_q
);
    st2_t                     s2_d, s2_q;
    st3_t                     s3_d;
    logic        [RCP_W-1:0]  rcp;
    logic signed [PROD_W-1:0] diff_x;
    logic signed [PROD_W-1:0] rcp_x;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] norm;
    logic signed [PROD_W-1:0] gained;

    fbdp_recip_rom #(
        .IDX_W (IDX_W),
        .RCP_W (RCP_W)
    ) i_rom (
        .idx (s1_q.mag[SUM_W-1 -: IDX_W]),
        .rcp (rcp)
    );

    always_comb begin
        s2_d.vld  = s1_q.vld;
        s2_d.diff = s1_q.diff;
        s2_d.rcp  = rcp;

        diff_x   = {{(PROD_W-SUM_W){s2_q.diff[SUM_W-1]}}, s2_q.diff};
        rcp_x    = {{(PROD_W-RCP_W){1'b0}}, s2_q.rcp};
        prod     = diff_x * rcp_x;
        norm     = prod >>> NORM_SHIFT;
        gained   = norm <<< gain_sel;
        s3_d.vld = s2_q.vld;
        s3_d.pos = gained[OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s2_q <= s2_d;
            s3_q <= s3_d;
        end
    end
endmodule

// File: rtl/beam_fb_datapath.sv
module beam_fb_datapath
    import fbdp_pkg::*;
#(
    parameter int NORM_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SMP_W-1:0]  ch_a,
    input  logic [SMP_W-1:0]  ch_b,
    input  logic [GAIN_W-1:0] gain_sel,
    input  logic              fb_en,
    input  logic              dly_en,
    input  logic              invert,
    input  logic              train_start,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_word
);
    st1_t                    s1_q;
    st3_t                    s3_q;
    st4_t                    s4_d, s4_q;
    logic signed [OUT_W-1:0] corr;

    fbdp_sumdiff i_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .ch_a     (ch_a),
        .ch_b     (ch_b),
        .s1_q     (s1_q)
    );

    fbdp_scale #(
        .NORM_SHIFT (NORM_SHIFT)
    ) i_scale (
        .clk      (clk),
        .rst_n    (rst_n),
        .s1_q     (s1_q),
        .gain_sel (gain_sel),
        .s3_q     (s3_q)
    );

    always_comb begin
        corr     = s3_q.pos + (dly_en ? s4_q.acc : '0);
        s4_d     = s4_q;
        s4_d.vld = s3_q.vld;
        if (s3_q.vld) begin
            if (fb_en) begin
                s4_d.word = invert ? -corr : corr;
                s4_d.acc  = corr;
            end else begin
                s4_d.word = '0;
            end
        end
        if (train_start) s4_d.acc = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s4_q <= '0;
        else        s4_q <= s4_d;
    end

    assign out_valid = s4_q.vld;
    assign out_word  = s4_q.word;
endmodule

// File: rtl/fbdp_checker.sv
module fbdp_checker
    import fbdp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             fb_en,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_word
);
    logic [2:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

    a_r8_fb_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd1 && out_valid && !$past(fb_en)) |-> (out_word == '0));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd1 && !out_valid) |-> $stable(out_word));

    a_r9_known: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_word));
endmodule

bind beam_fb_datapath fbdp_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .fb_en     (fb_en),
    .out_valid (out_valid),
    .out_word  (out_word)
);

// File: tb/test_beam_fb_datapath.sv
module test_beam_fb_datapath;
    localparam time CYC = 20ns;

    typedef struct packed {
        logic signed [13:0] a;
        logic signed [13:0] b;
        logic        [2:0]  g;
        logic               fb;
        logic               dl;
        logic               inv;
    } vec_t;

    // stimulus table: R2 sign orders and indices, R3 gains, R7 inversion, R8 feedback off
    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{ 14'sd3000,  14'sd1000, 3'd0, 1'b1, 1'b0, 1'b0},
        '{ 14'sd1000,  14'sd3000, 3'd0, 1'b1, 1'b0, 1'b0},
        '{ 14'sd8000,  14'sd7000, 3'd0, 1'b1, 1'b0, 1'b0},
        '{ 14'sd100,   14'sd20,   3'd0, 1'b1, 1'b0, 1'b0},
        '{-14'sd5000, -14'sd2000, 3'd1, 1'b1, 1'b0, 1'b0},
        '{ 14'sd3000,  14'sd1000, 3'd2, 1'b1, 1'b0, 1'b0},
        '{ 14'sd3000,  14'sd1000, 3'd3, 1'b1, 1'b0, 1'b0},
        '{ 14'sd3000,  14'sd1000, 3'd4, 1'b1, 1'b0, 1'b0},
        '{ 14'sd3000,  14'sd1000, 3'd5, 1'b1, 1'b0, 1'b1},
        '{ 14'sd3000,  14'sd1000, 3'd6, 1'b1, 1'b0, 1'b0},
        '{ 14'sd3000,  14'sd1000, 3'd7, 1'b1, 1'b0, 1'b1},
        '{ 14'sd6000,  14'sd500,  3'd3, 1'b0, 1'b0, 1'b0}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [13:0] ch_a = '0;
    logic signed [13:0] ch_b = '0;
    logic        [2:0]  gain_sel = '0;
    logic               fb_en = 1'b0;
    logic               dly_en = 1'b0;
    logic               invert = 1'b0;
    logic               train_start = 1'b0;
    logic               out_valid;
    logic        [13:0] out_word;

    int                 checks = 0;
    int                 errors = 0;
    logic signed [13:0] prev = '0;
    logic        [13:0] exp_w;
    logic        [13:0] held;

    always #(CYC/2) clk = ~clk;

    beam_fb_datapath i_beam_fb_datapath (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .ch_a        (ch_a),
        .ch_b        (ch_b),
        .gain_sel    (gain_sel),
        .fb_en       (fb_en),
        .dly_en      (dly_en),
        .invert      (invert),
        .train_start (train_start),
        .out_valid   (out_valid),
        .out_word    (out_word)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference model built from R2..R8; updates the stored correction
    task automatic model(input logic signed [13:0] a, b, input logic [2:0] g,
                         input logic f, d, i, output logic [13:0] w);
        longint s, m, idx, rc, p, n, x;
        logic signed [13:0] c;
        s   = longint'(a) + longint'(b);
        m   = (s < 0) ? -s : s;
        idx = m >> 7;
        rc  = 65535 / (idx + 1);
        p   = (longint'(a) - longint'(b)) * rc;
        n   = p >>> 12;
        x   = n <<< g;
        if (d) x = x + longint'(prev);
        c = x[13:0];
        if (f) begin
            w    = i ? -c : c;
            prev = c;
        end else begin
            w = '0;
        end
    endtask

    task automatic bunch(input logic signed [13:0] a, b, input logic [2:0] g,
                         input logic f, d, i, input string req);
        @(negedge clk);
        ch_a = a; ch_b = b; gain_sel = g; fb_en = f; dly_en = d; invert = i;
        in_valid = 1'b1;
        model(a, b, g, f, d, i, exp_w);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R1 early", longint'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R1 strobe", longint'(out_valid), 1);
        chk(out_word == exp_w, req, longint'(signed'(out_word)), longint'(signed'(exp_w)));
    endtask

    task automatic pulse_train_start();
        @(negedge clk);
        train_start = 1'b1;
        @(negedge clk);
        train_start = 1'b0;
        prev = '0;
    endtask

    initial begin
        #(CYC * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(out_valid == 1'b0, "R9 valid", longint'(out_valid), 0);
        chk(out_word == '0, "R9 word", longint'(out_word), 0);
        rst_n = 1'b1;

        // R9: stored correction starts at zero
        bunch(14'sd3000, 14'sd1000, 3'd0, 1'b1, 1'b1, 1'b0, "R9 acc zero");
        pulse_train_start();

        for (int k = 0; k < NV; k++)
            bunch(VEC[k].a, VEC[k].b, VEC[k].g, VEC[k].fb, VEC[k].dl, VEC[k].inv, "R2 R3 R7 R8 table");

        // R10: word held while no bunch arrives
        held = out_word;
        repeat (6) @(negedge clk);
        chk(out_valid == 1'b0, "R10 valid", longint'(out_valid), 0);
        chk(out_word == held, "R10 hold", longint'(out_word), longint'(held));

        // R4: wrap at x128 with wide difference
        bunch(14'sd8000, -14'sd8000, 3'd7, 1'b1, 1'b0, 1'b0, "R4 wrap");
        bunch(-14'sd8192, 14'sd8191, 3'd6, 1'b1, 1'b0, 1'b1, "R4 wrap inv");

        // R5: accumulation over three bunches of one train
        pulse_train_start();
        bunch(14'sd3000, 14'sd1000, 3'd2, 1'b1, 1'b1, 1'b0, "R5 bunch1");
        bunch(14'sd2500, 14'sd1500, 3'd2, 1'b1, 1'b1, 1'b0, "R5 bunch2");
        bunch(14'sd4000, 14'sd1000, 3'd2, 1'b1, 1'b1, 1'b0, "R5 bunch3");

        // R7: stored value is pre-inversion
        bunch(14'sd3000, 14'sd1000, 3'd1, 1'b1, 1'b1, 1'b1, "R7 inv store");
        bunch(14'sd3000, 14'sd1000, 3'd1, 1'b1, 1'b1, 1'b0, "R7 after inv");

        // R8: feedback off leaves stored value
        bunch(14'sd5000, 14'sd100, 3'd3, 1'b0, 1'b1, 1'b0, "R8 off");
        bunch(14'sd1000, 14'sd900, 3'd0, 1'b1, 1'b1, 1'b0, "R8 kept");

        // R6: train start clears the stored correction
        pulse_train_start();
        bunch(14'sd1000, 14'sd900, 3'd0, 1'b1, 1'b1, 1'b0, "R6 cleared");

        // R4: accumulation wraps too
        pulse_train_start();
        bunch(14'sd8000, 14'sd7000, 3'd7, 1'b1, 1'b1, 1'b0, "R4 acc1");
        bunch(14'sd8000, 14'sd7000, 3'd7, 1'b1, 1'b1, 1'b0, "R4 acc2");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule